// File: doc/BRIEF.md
# Banked Packet Buffer Power Controller

This block governs a packet queue whose storage is split into equal memory banks, each with its own supply switch. A packet arrives as a valid pulse with a byte length. If the server is free and nothing is waiting, the packet goes straight to service and uses no storage. If the server is busy, the packet's length joins a FIFO of waiting packets and its bytes are appended to the buffered region. That region is kept packed from bank 0 upward, so the number of powered banks follows live occupancy. A service completion pulse frees the server. If packets are waiting, the head packet's bytes leave the buffer and that packet enters service.

The memory arrays are not part of the block. For each bank it drives a power enable and a one-cycle write strobe. A strobe never reaches a bank whose power was not already on in the previous cycle. A packet that finds the queue at its packet limit, or that would overrun the byte capacity, is dropped. The drop raises a pulse and increments a counter. Every accepted packet adds a cost to a saturating energy total. The cost is the arrival cost plus the service cost, plus the queuing cost multiplied by the number of banks powered once the packet is stored. All three costs are register inputs.

Top module: `bpb_power_ctrl`

## Requirements
- R1: An arrival that finds the server idle with an empty queue goes to service directly. The queued count stays 0 and no bank power or write strobe is raised for it.
- R2: An arrival while the server is busy is stored if it fits. The queued count rises by one and the buffered bytes grow by the packet length.
- R3: In every cycle, bank i is powered when the buffered byte count exceeds i times the bank size, or when a write to bank i is pending or in progress. When the queue is empty and no write is in flight, every bank is off.
- R4: The write strobes of a stored packet cover exactly the banks spanned by its byte range [old fill, new fill). They pulse for one cycle, two cycles after the arrival cycle, and each strobed bank is powered in the cycle before its strobe.
- R5: An arrival is dropped when the queue already holds the packet limit, or when its bytes would exceed the number of banks times the bank size. The drop pulse is then high for one cycle, the drop counter rises by one (wrapping), and the queue and fill are unchanged.
- R6: A completion while busy with packets waiting removes the head packet's bytes, lowers the count by one and keeps the server busy. With no packets waiting, the server becomes idle. A completion while idle has no effect.
- R7: When a completion and an arrival occur in the same cycle, the completion is processed first, and the arrival may use the freed slot, the freed bytes or the idle server.
- R8: A bypassed packet adds arrival cost plus service cost to the energy total. A stored packet adds arrival cost, plus queuing cost times the number of banks powered for the fill after storing, plus service cost. A dropped packet adds nothing.
- R9: The energy total saturates at its all-ones value and never wraps or decreases between resets.
- R10: Reset (synchronous, active high) clears the queue, the fill, the server state, the drop counter and the energy total, and turns every bank off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | Packet arrival pulse |
| arr_len | input | LENW | Arriving packet length in bytes |
| svc_done | input | 1 | Service completion pulse |
| cost_arrive | input | CW | Energy charged per accepted arrival |
| cost_queue | input | CW | Energy charged per powered bank for a stored packet |
| cost_service | input | CW | Energy charged per accepted packet for service |
| bank_pwr | output | NB | Per-bank power enable |
| bank_wr | output | NB | Per-bank write strobe |
| q_count | output | clog2(QCAP+1) | Packets currently queued |
| drop_pulse | output | 1 | One-cycle drop indication |
| drop_count | output | DCW | Dropped packet counter |
| energy | output | EW | Saturating energy total |

## Verification
A fill register that drifts from the real byte total shows on `bank_pwr` in the first idle cycle after the faulty update. The same drift shows later as a wrong drop decision, or as a wrong bank count in the next charge to `energy`. A server-state error first shows on the next arrival, as a wrongly stored or wrongly bypassed packet, and so as a wrong `q_count`. A misordered same-cycle completion shows as a spurious drop pulse at a full queue. Every output is compared with an arithmetic model once per cycle, so any divergence is reported within one cycle of reaching a port.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_BYPASS = 2'd1,
        ACT_STORE  = 2'd2,
        ACT_DROP   = 2'd3
    } arr_act_e;

    typedef struct packed {
        logic pop;
        logic busy;
    } svc_state_s;

endpackage

// File: rtl/bpb_len_fifo.sv
module bpb_len_fifo #(
    parameter int DEPTH = 100,
    parameter int W     = 17
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [NW-1:0] cnt_q;

    function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= advance(wr_q);
            if (pop)  rd_q <= advance(rd_q);
            cnt_q <= cnt_q + NW'(push) - NW'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> ((cnt_q < NW'(DEPTH)) || pop)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/bpb_bank_span.sv
module bpb_bank_span #(
    parameter int NB   = 4,
    parameter int BANK = 32768,
    parameter int FW   = 18
) (
    input  logic [FW-1:0] lo,
    input  logic [FW-1:0] hi,
    output logic [NB-1:0] mask
);
    for (genvar i = 0; i < NB; i++) begin : g_bank
        localparam logic [FW-1:0] BLO = FW'(i * BANK);
        localparam logic [FW-1:0] BHI = FW'((i + 1) * BANK);
        assign mask[i] = (hi > lo) && (hi > BLO) && (lo < BHI);
    end
endmodule

// File: rtl/bpb_energy_acc.sv
module bpb_energy_acc #(
    parameter int NB = 4,
    parameter int CW = 16,
    parameter int EW = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     charge,
    input  logic [$clog2(NB+1)-1:0]  nbanks,
    input  logic [CW-1:0]            ea,
    input  logic [CW-1:0]            eq,
    input  logic [CW-1:0]            es,
    output logic [EW-1:0]            acc
);
    localparam int NBW = $clog2(NB + 1);
    localparam int CHW = CW + NBW + 2;

    logic [EW-1:0]  acc_q;
    logic [CHW-1:0] cost;
    logic [EW:0]    sum;
    logic           rst_d;

    assign cost = CHW'(ea) + CHW'(nbanks) * CHW'(eq) + CHW'(es);
    assign sum  = {1'b0, acc_q} + (EW+1)'(cost);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)         acc_q <= '0;
        else if (charge) acc_q <= sum[EW] ? '1 : sum[EW-1:0];
    end

    assign acc = acc_q;

    AST_ENERGY_MONOTONIC: assert property (@(posedge clk) disable iff (rst || rst_d)
        acc_q >= $past(acc_q)); // R9
    AST_ENERGY_HOLDS_MAX: assert property (@(posedge clk) disable iff (rst || rst_d)
        ($past(acc_q) == '1) |-> (acc_q == '1)); // R9
endmodule

// File: rtl/bpb_power_ctrl.sv
module bpb_power_ctrl
    import bpb_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BANK = 32768,
    parameter int QCAP = 100,
    parameter int LENW = 17,
    parameter int CW   = 16,
    parameter int EW   = 32,
    parameter int DCW  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       arr_valid,
    input  logic [LENW-1:0]            arr_len,
    input  logic                       svc_done,
    input  logic [CW-1:0]              cost_arrive,
    input  logic [CW-1:0]              cost_queue,
    input  logic [CW-1:0]              cost_service,
    output logic [NB-1:0]              bank_pwr,
    output logic [NB-1:0]              bank_wr,
    output logic [$clog2(QCAP+1)-1:0]  q_count,
    output logic                       drop_pulse,
    output logic [DCW-1:0]             drop_count
    ,
    output logic [EW-1:0]              energy
);
    localparam int TOTAL = NB * BANK;
    localparam int FW    = $clog2(TOTAL + 1);
    localparam int NW    = $clog2(QCAP + 1);
    localparam int NBW   = $clog2(NB + 1);

    logic [FW-1:0]   fill_q, fill_a, fill_n;
    logic [NW-1:0]   cnt_q, cnt_a;
    logic [LENW-1:0] head_len;
    logic            busy_q;
    svc_state_s      svc;
    arr_act_e        act;
    logic            fits, store, bypass;
    logic [NB-1:0]   pend_q, wr_q, pend_d, occ_mask, need_mask;
    logic            drop_q;
    logic [DCW-1:0]  drop_cnt_q;

    // completion is resolved before the arrival of the same cycle
    always_comb begin
        svc.pop  = svc_done && busy_q && (cnt_q != '0);
        svc.busy = (svc_done && busy_q) ? svc.pop : busy_q;
    end

    assign fill_a = fill_q - (svc.pop ? FW'(head_len) : '0);
    assign cnt_a  = cnt_q - NW'(svc.pop);
    assign fits   = ({1'b0, fill_a} + (FW+1)'(arr_len)) <= (FW+1)'(TOTAL);

    always_comb begin
        act = ACT_NONE;
        if (arr_valid) begin
            if (!svc.busy && cnt_a == '0)          act = ACT_BYPASS;
            else if (cnt_a < NW'(QCAP) && fits)    act = ACT_STORE;
            else                                   act = ACT_DROP;
        end
    end

    assign store  = (act == ACT_STORE);
    assign bypass = (act == ACT_BYPASS);
    assign fill_n = fill_a + (store ? FW'(arr_len) : '0);

    bpb_len_fifo #(.DEPTH(QCAP), .W(LENW)) u_len_fifo (
        .clk(clk), .rst(rst), .push(store), .pop(svc.pop),
        .din(arr_len), .head(head_len), .count(cnt_q)
    );

    bpb_bank_span #(.NB(NB), .BANK(BANK), .FW(FW)) u_span_new (
        .lo(fill_a), .hi(fill_n), .mask(pend_d)
    );
    bpb_bank_span #(.NB(NB), .BANK(BANK), .FW(FW)) u_span_need (
        .lo('0), .hi(fill_n), .mask(need_mask)
    );
    bpb_bank_span #(.NB(NB), .BANK(BANK), .FW(FW)) u_span_occ (
        .lo('0), .hi(fill_q), .mask(occ_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q     <= '0;
            busy_q     <= 1'b0;
            pend_q     <= '0;
            wr_q       <= '0;
            drop_q     <= 1'b0;
            drop_cnt_q <= '0;
        end else begin
            fill_q <= fill_n;
            busy_q <= svc.busy || bypass;
            pend_q <= pend_d;
            wr_q   <= pend_q;
            drop_q <= (act == ACT_DROP);
            if (act == ACT_DROP) drop_cnt_q <= drop_cnt_q + 1'b1;
        end
    end

    bpb_energy_acc #(.NB(NB), .CW(CW), .EW(EW)) u_energy (
        .clk(clk), .rst(rst), .charge(store || bypass),
        .nbanks(store ? NBW'($countones(need_mask)) : '0),
        .ea(cost_arrive), .eq(cost_queue), .es(cost_service), .acc(energy)
    );

    assign bank_pwr   = occ_mask | pend_q | wr_q;
    assign bank_wr    = wr_q;
    assign q_count    = cnt_q;
    assign drop_pulse = drop_q;
    assign drop_count = drop_cnt_q;

    AST_WRITE_PREPOWERED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((bank_wr & ~$past(bank_pwr)) == '0)); // R4
    AST_BYPASS_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (q_count == '0 && bank_wr == '0)); // R1
    AST_EMPTY_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0 && pend_q == '0 && wr_q == '0) |-> (bank_pwr == '0)); // R3
    AST_DROP_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> (drop_count == DCW'($past(drop_count) + 1'b1))); // R5
endmodule

// File: tb/bpb_power_ctrl_bench.sv
`timescale 1ns/1ps
module bpb_power_ctrl_bench;
    localparam int NB = 4, BANK = 16, QC = 6, LW = 6, CWB = 8, EWB = 16, DW = 8;
    localparam int TOT = NB * BANK;
    localparam int EMAX = 65535;

    logic clk = 0, rst = 1, arr_valid = 0, svc_done = 0;
    logic [LW-1:0] arr_len = '0;
    logic [CWB-1:0] ca = 0, cq = 0, cs = 0;
    logic [NB-1:0] bank_pwr, bank_wr;
    logic [2:0] q_count;
    logic drop_pulse;
    logic [DW-1:0] drop_count;
    logic [EWB-1:0] energy;

    always #2 clk = ~clk;

    bpb_power_ctrl #(.NB(NB), .BANK(BANK), .QCAP(QC), .LENW(LW), .CW(CWB), .EW(EWB), .DCW(DW))
    u_bpb_power_ctrl (
        .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_len(arr_len), .svc_done(svc_done),
        .cost_arrive(ca), .cost_queue(cq), .cost_service(cs),
        .bank_pwr(bank_pwr), .bank_wr(bank_wr), .q_count(q_count),
        .drop_pulse(drop_pulse), .drop_count(drop_count), .energy(energy)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int mq[QC];
    int mcnt, mfill, men;
    bit mbusy, mdrop;
    logic [DW-1:0] mdrops;
    logic [NB-1:0] mpend, mwr;

    function automatic logic [NB-1:0] span(int lo, int hi);
        logic [NB-1:0] m;
        for (int i = 0; i < NB; i++) m[i] = (hi > lo) && (hi > i*BANK) && (lo < (i+1)*BANK);
        return m;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mcnt = 0; mfill = 0; men = 0; mbusy = 0; mdrop = 0;
        mdrops = '0; mpend = '0; mwr = '0;
    endtask

    task automatic do_reset();
        rst = 1; arr_valid = 0; svc_done = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        chk(q_count == 0, "R10", "q_count", q_count, 0);
        chk(bank_pwr == 0 && bank_wr == 0, "R10", "bank_pwr", bank_pwr, 0);
        chk(drop_count == 0 && drop_pulse == 0, "R10", "drop_count", drop_count, 0);
        chk(energy == 0, "R10", "energy", energy, 0);
    endtask

    task automatic step(bit a, int l, bit d);
        int lo, nb;
        arr_valid = a; arr_len = LW'(l); svc_done = d;
        @(posedge clk);
        // R7: completion before arrival
        if (d && mbusy) begin
            if (mcnt > 0) begin
                mfill -= mq[0];
                for (int j = 0; j < mcnt - 1; j++) mq[j] = mq[j+1];
                mcnt--;
            end else mbusy = 0;
        end
        mwr = mpend; mpend = '0; mdrop = 0;
        if (a) begin
            if (!mbusy && mcnt == 0) begin
                mbusy = 1;
                men += ca + cs;
            end else if (mcnt < QC && mfill + l <= TOT) begin
                lo = mfill; mfill += l; mq[mcnt] = l; mcnt++;
                nb = (mfill + BANK - 1) / BANK;
                men += ca + nb * cq + cs;
                mpend = span(lo, mfill);
            end else begin
                mdrop = 1; mdrops++;
            end
        end
        if (men > EMAX) men = EMAX;
        @(negedge clk);
        arr_valid = 0; svc_done = 0;
        chk(q_count == mcnt, "R2/R6", "q_count", q_count, mcnt);
        chk(bank_pwr == (span(0, mfill) | mpend | mwr), "R3", "bank_pwr", bank_pwr, span(0, mfill) | mpend | mwr);
        chk(bank_wr == mwr, "R4", "bank_wr", bank_wr, mwr);
        chk(drop_pulse == mdrop, "R5", "drop_pulse", drop_pulse, mdrop);
        chk(drop_count == mdrops, "R5", "drop_count", drop_count, mdrops);
        chk(energy == men, "R8/R9", "energy", energy, men);
    endtask

    initial begin
        logic [15:0] lf;
        do_reset();
        ca = 5; cq = 3; cs = 7;
        step(1, 10, 0);
        chk(q_count == 0 && bank_pwr == 0, "R1", "bypass storage", bank_pwr, 0);
        chk(energy == 12, "R8", "bypass cost", energy, 12);
        step(1, 20, 0);
        chk(energy == 30, "R8", "store cost two banks", energy, 30);
        step(0, 0, 0);
        chk(bank_wr == 4'b0011, "R4", "write strobe span", bank_wr, 3);
        step(0, 0, 0);
        chk(bank_pwr == 4'b0011, "R3", "settled power", bank_pwr, 3);
        step(1, 40, 0);
        step(1, 10, 0);
        chk(drop_pulse == 1, "R5", "byte overflow drop", drop_pulse, 1);
        step(0, 0, 1);
        step(0, 0, 0); step(0, 0, 0);
        chk(bank_pwr == 4'b0111 && q_count == 1, "R6", "after dequeue", bank_pwr, 7);
        for (int k = 0; k < 5; k++) step(1, 1, 0);
        step(1, 1, 0);
        chk(drop_pulse == 1 && q_count == QC, "R5", "count limit drop", q_count, QC);
        step(1, 2, 1);
        chk(drop_pulse == 0 && q_count == QC, "R7", "same-cycle accept", q_count, QC);
        for (int k = 0; k < 10; k++) step(0, 0, 1);
        step(0, 0, 0); step(0, 0, 0);
        chk(bank_pwr == 0 && q_count == 0, "R3", "drained all off", bank_pwr, 0);
        step(1, 5, 0);
        chk(q_count == 0, "R1", "bypass after idle", q_count, 0);
        step(0, 0, 1);

        ca = 2; cq = 1; cs = 3;
        lf = 16'hACE1;
        for (int k = 0; k < 2500; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], (lf[10:6] % 24) + 1, lf[3] & lf[4]);
        end
        for (int k = 0; k < 2500; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], (lf[11:7] % 30) + 1, lf[2] | lf[3]);
        end

        do_reset();
        ca = 255; cq = 255; cs = 255;
        for (int k = 0; k < 150; k++) step(1, 8, 1);
        chk(energy == EMAX, "R9", "saturated energy", energy, EMAX);
        step(1, 8, 0);
        step(1, 8, 0);
        chk(energy == EMAX, "R9", "held at max", energy, EMAX);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule